// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block sits between a group of eight on-chip peripherals and a small CPU core. Each peripheral raises a one-cycle event pulse. The pulse sets a latched status flag for that source. A flag whose per-source enable bit is 1 forms a pending request. The block combines the pending requests into a single request line to the CPU, gated by a global mask level that comes from the CPU. It also computes a vector number for the highest-priority pending source. Source 0 has the highest priority and the vector is `VEC_BASE + index`. When the CPU asserts acknowledge, the block captures that vector and holds it until the next acknowledge.

Flags are never cleared by acceptance. Software clears a flag over a simple strobe-based register bus by writing 0 to the flag bit. The write only takes effect if software has read that flag while it was 1 since the flag was last set. For one cycle after the CPU signals that it wrote its condition-code register, the request line is held low.

Software may disable a source while that source's request is visible to the CPU. The block remembers this race. It keeps the request line up until the next acknowledge. At that acknowledge it presents the highest-priority other pending request, or vector 0 (the reset vector) when nothing else is pending.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register and the enable register read 0, `irq_o` is 0 and `vec_o` is 0.
- R2: An `evt_i` pulse on bit i sets flag i at the next clock edge. If a pulse and a valid software clear of the same bit occur in the same cycle, the flag stays 1.
- R3: A bus write to the flag register (`bus_sel_i`=0) with data bit i = 0 clears flag i only if flag i was read as 1 since it was last set. Writing 1 to a flag bit never changes it.
- R4: A new event on a flag discards any earlier read. A following write of 0 leaves the flag set until the flag is read again.
- R5: Asserting `ack_i` never clears a flag. Flags change only through events and flag-register writes.
- R6: `irq_o` is 1 when some flag i and enable i (enable register, `bus_sel_i`=1) are both 1, provided `imask_i` is 0. While `imask_i` is 1, `irq_o` is 0.
- R7: In the cycle after a cycle with `ccr_wr_i`=1, `irq_o` is 0.
- R8: Among pending enabled sources the lowest index wins. The vector is `VEC_BASE`+index, with `VEC_BASE`=16 by default.
- R9: `vec_o` loads the current vector at a clock edge where `ack_i`=1 and is otherwise unchanged.
- R10: Clearing an enable bit whose source request is visible on `irq_o` (not masked, not inhibited) keeps `irq_o` at 1 until the next acknowledge. That acknowledge loads the highest-priority remaining request, or 0 if none remains. If the request was masked at that moment, no such effect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Per-source event pulses that set flags |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 1 | Register select: 0 flags, 1 enables |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register (combinational) |
| imask_i | input | 1 | Global mask level from the CPU |
| ccr_wr_i | input | 1 | Marks an instruction that writes the condition-code register |
| ack_i | input | 1 | CPU acceptance of the request |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector number captured at the last acknowledge |

## Verification
A wrong read-before-clear tracking state shows up at the next flag read after a write of 0. The flag either clears when it should not, or survives a legal clear. This is visible one cycle after the write. A stuck inhibit or race state appears on `irq_o` in the very next cycle. A race state that is never dropped shows as `irq_o` still high after an acknowledge that should end it. A priority fault appears in `vec_o` one cycle after the acknowledge, so every scenario ends with an acknowledge, a flag read and an `irq_o` check.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int N_SRC    = 8;
    parameter int VEC_W    = 8;
    parameter int VEC_BASE = 16;
    localparam int IDX_W   = $clog2(N_SRC);
    localparam logic [VEC_W-1:0] RESET_VEC = '0;

    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_EN   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        reg_sel_e         sel;
        logic [N_SRC-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_W'(VEC_BASE) + VEC_W'(idx);
    endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt,
    input  logic             rd_flag,
    input  logic             wr_flag,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] flags
);
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] armed_q;
    logic [N_SRC-1:0] clr;

    assign flags = flag_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // a clear needs a write of 0 to a flag that was seen as 1
        assign clr[i] = wr_flag & ~wdata[i] & armed_q[i] & flag_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i]  <= 1'b0;
                armed_q[i] <= 1'b0;
            end else begin
                if (evt[i]) begin
                    flag_q[i]  <= 1'b1;
                    armed_q[i] <= 1'b0;
                end else if (clr[i]) begin
                    flag_q[i]  <= 1'b0;
                    armed_q[i] <= 1'b0;
                end else if (rd_flag && flag_q[i]) begin
                    armed_q[i] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
    import irqc_pkg::*;
(
    input  logic [N_SRC-1:0] req,
    output pick_t            pick
);
    always_comb begin
        pick = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en_drop,
    input  logic             imask,
    input  logic             ccr_wr,
    input  logic             ack,
    output logic             irq,
    output logic             race
);
    logic             inh_q;
    logic             race_q;
    logic             open_w;
    logic [N_SRC-1:0] vis;
    logic             race_set;

    assign open_w   = ~imask & ~inh_q;
    assign vis      = req & {N_SRC{open_w}};
    assign race_set = |(en_drop & vis);
    assign race     = race_q;
    assign irq      = ((|req) | race_q) & open_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            inh_q  <= 1'b0;
            race_q <= 1'b0;
        end else begin
            inh_q <= ccr_wr;
            if (race_set)
                race_q <= 1'b1;
            else if (ack)
                race_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic             bus_sel_i,
    input  logic [N_SRC-1:0] bus_wdata_i,
    output logic [N_SRC-1:0] bus_rdata_o,
    input  logic             imask_i,
    input  logic             ccr_wr_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o
);
    bus_req_t         bus;
    logic [N_SRC-1:0] flags;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] req;
    logic [N_SRC-1:0] en_drop;
    logic             wr_en;
    logic             race;
    pick_t            pick;
    logic [VEC_W-1:0] vec_next;
    logic [VEC_W-1:0] vec_q;

    assign bus.rd    = bus_rd_i;
    assign bus.wr    = bus_wr_i;
    assign bus.sel   = reg_sel_e'(bus_sel_i);
    assign bus.wdata = bus_wdata_i;

    assign wr_en   = bus.wr && bus.sel == SEL_EN;
    assign en_drop = {N_SRC{wr_en}} & en_q & ~bus.wdata;

    irqc_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_i),
        .rd_flag (bus.rd && bus.sel == SEL_FLAG),
        .wr_flag (bus.wr && bus.sel == SEL_FLAG),
        .wdata   (bus.wdata),
        .flags   (flags)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en)
            en_q <= bus.wdata;
    end

    assign req = flags & en_q;

    irqc_prio_enc u_prio (
        .req  (req),
        .pick (pick)
    );

    irqc_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .en_drop (en_drop),
        .imask   (imask_i),
        .ccr_wr  (ccr_wr_i),
        .ack     (ack_i),
        .irq     (irq_o),
        .race    (race)
    );

    // a race with nothing else pending falls back to the reset vector
    always_comb begin
        if (pick.valid)
            vec_next = vec_of(pick.idx);
        else
            vec_next = RESET_VEC;
    end

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= RESET_VEC;
        else if (ack_i)
            vec_q <= vec_next;
    end

    assign vec_o       = vec_q;
    assign bus_rdata_o = (bus.sel == SEL_EN) ? en_q : flags;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] evt_i,
    input logic             bus_wr_i,
    input logic             imask_i,
    input logic             ccr_wr_i,
    input logic             ack_i,
    input logic             irq_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [N_SRC-1:0] flags
);
    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));

    // R5
    no_clear_wo_write_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_i |=> ((flags & $past(flags)) == $past(flags)));

    // R6
    mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        imask_i |-> !irq_o);

    // R7
    ccr_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        ccr_wr_i |=> !irq_o);

    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> $stable(vec_o));
endmodule

bind irq_flag_ctrl irqc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .bus_wr_i (bus_wr_i),
    .imask_i  (imask_i),
    .ccr_wr_i (ccr_wr_i),
    .ack_i    (ack_i),
    .irq_o    (irq_o),
    .vec_o    (vec_o),
    .flags    (flags)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
    localparam int BASE = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt = '0;
    logic       rd = 1'b0, wr = 1'b0, sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       imask = 1'b0, ccr_wr = 1'b0, ack = 1'b0;
    logic       irq;
    logic [7:0] vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_flag_ctrl dut (
        .clk(clk), .rst(rst), .evt_i(evt), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_sel_i(sel), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .imask_i(imask), .ccr_wr_i(ccr_wr), .ack_i(ack),
        .irq_o(irq), .vec_o(vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick; @(negedge clk); endtask

    task automatic wr_reg(input logic s, input logic [7:0] d);
        sel = s; wdata = d; wr = 1'b1; tick; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic s, output logic [7:0] d);
        sel = s; rd = 1'b1; #1 d = rdata; tick; rd = 1'b0;
    endtask

    task automatic fire(input logic [7:0] m);
        evt = m; tick; evt = '0;
    endtask

    task automatic do_ack;
        ack = 1'b1; tick; ack = 1'b0;
    endtask

    task automatic cleanup;
        logic [7:0] d;
        rd_reg(1'b0, d);
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h00);
        do_ack;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd_reg(1'b0, d); chk("R1 flags", d, 0);
        rd_reg(1'b1, d); chk("R1 enables", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 vec", vec, 0);
    endtask

    task automatic t_set_clear;
        logic [7:0] d;
        fire(8'h05);
        rd_reg(1'b0, d); chk("R2 set", d, 8'h05);
        cleanup;
        fire(8'h05);
        wr_reg(1'b0, 8'h00);
        rd_reg(1'b0, d); chk("R3 unread clear ignored", d, 8'h05);
        wr_reg(1'b0, 8'hFF);
        rd_reg(1'b0, d); chk("R3 write one no effect", d, 8'h05);
        wr_reg(1'b0, 8'hFE);
        rd_reg(1'b0, d); chk("R3 clear bit0 only", d, 8'h04);
        wr_reg(1'b0, 8'h00);
        rd_reg(1'b0, d); chk("R3 clear rest", d, 8'h00);
    endtask

    task automatic t_rearm;
        logic [7:0] d;
        fire(8'h01);
        rd_reg(1'b0, d);
        fire(8'h01);
        wr_reg(1'b0, 8'h00);
        rd_reg(1'b0, d); chk("R4 new set needs read", d, 8'h01);
        evt = 8'h01; sel = 1'b0; wdata = 8'h00; wr = 1'b1;
        tick; evt = '0; wr = 1'b0;
        rd_reg(1'b0, d); chk("R2 set wins over clear", d, 8'h01);
        wr_reg(1'b0, 8'h00);
        rd_reg(1'b0, d); chk("R3 legal clear", d, 8'h00);
    endtask

    task automatic t_prio_mask;
        logic [7:0] d;
        fire(8'h48);
        chk("R6 no enable no irq", irq, 0);
        wr_reg(1'b1, 8'hFF);
        chk("R6 irq", irq, 1);
        do_ack;
        chk("R8 vec idx3", vec, BASE + 3);
        rd_reg(1'b0, d); chk("R5 ack keeps flags", d, 8'h48);
        imask = 1'b1; #1;
        chk("R6 masked", irq, 0);
        tick; imask = 1'b0; #1;
        chk("R6 unmasked", irq, 1);
        wr_reg(1'b0, 8'hF7);
        rd_reg(1'b0, d); chk("R3 bit3 cleared", d, 8'h40);
        do_ack;
        chk("R8 vec idx6", vec, BASE + 6);
        fire(8'h01);
        tick;
        chk("R9 vec held", vec, BASE + 6);
        do_ack;
        chk("R8 vec idx0", vec, BASE + 0);
        rd_reg(1'b0, d);
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_inhibit;
        fire(8'h02);
        wr_reg(1'b1, 8'h02);
        chk("R7 irq before", irq, 1);
        ccr_wr = 1'b1; tick; ccr_wr = 1'b0;
        chk("R7 inhibited", irq, 0);
        tick;
        chk("R7 released", irq, 1);
        cleanup;
    endtask

    task automatic t_race_reset;
        logic [7:0] d;
        fire(8'h08);
        wr_reg(1'b1, 8'h08);
        do_ack;
        chk("R10 setup vec", vec, BASE + 3);
        wr_reg(1'b1, 8'h00);
        chk("R10 irq kept", irq, 1);
        do_ack;
        chk("R10 reset vec", vec, 0);
        chk("R10 irq dropped after ack", irq, 0);
        rd_reg(1'b0, d); chk("R5 race keeps flag", d, 8'h08);
        cleanup;
    endtask

    task automatic t_race_other;
        fire(8'h28);
        wr_reg(1'b1, 8'h28);
        wr_reg(1'b1, 8'h20);
        chk("R10 irq other", irq, 1);
        do_ack;
        chk("R10 other vec", vec, BASE + 5);
        chk("R10 other still pending", irq, 1);
        cleanup;
    endtask

    task automatic t_race_masked;
        fire(8'h08);
        wr_reg(1'b1, 8'h08);
        imask = 1'b1;
        wr_reg(1'b1, 8'h00);
        imask = 1'b0; #1;
        chk("R10 masked no race", irq, 0);
        cleanup;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        rst = 1'b0;
        tick;
        t_reset;
        t_set_clear;
        t_rearm;
        t_prio_mask;
        t_inhibit;
        t_race_reset;
        t_race_other;
        t_race_masked;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule